// File: doc/BRIEF.md
# I2C Two-Stage Bus Rate Generator

This block turns a single system clock into the timing strobes an I2C controller needs. Software writes one 8-bit control byte that holds two divider fields: an exponent N and a scalar M. The first stage divides the system clock by 2^N and produces a one-cycle sample strobe. The bit-level logic uses this strobe to sample SDA and SCL. The second stage counts those sample strobes and drives the master-mode SCL level at a lower rate. That rate is set separately through M. The SCL output has a 50% duty cycle and a full period of 10·(M+1)·2^N system clocks.

The control byte can only be written. A new value is held in the register right away. Each counter stage picks up its own field only when it wraps, so a period already in progress always runs to its end. When master mode is off, SCL is released high and the SCL counter is parked at zero. The sample strobe keeps running. Two one-cycle strobes mark each rising and falling SCL edge. The bit controller uses them to launch and capture data.

Top module: `i2c_rate_gen`

## Requirements
- R1: A write is taken when `cfg_wr_en` is high at a rising clock edge. Data bits [6:3] set M (0 to 15) and bits [2:0] set N (0 to 7). Bit 7 is reserved: its value changes no timing.
- R2: Synchronous active-low reset clears M and N to 0. After reset, `samp_stb` is high in every cycle, `scl_out` is 1, and `scl_rise`/`scl_fall` are 0.
- R3: `samp_stb` is a one-cycle pulse that repeats every 2^N system clocks. With N = 0 it is high in every cycle.
- R4: In master mode, each SCL level lasts 5·(M+1)·2^N system clocks and spans exactly 5·(M+1) sample strobes. The full period is 10·(M+1)·2^N clocks.
- R5: Changing M leaves the sample-strobe period unchanged.
- R6: `scl_out` changes while master mode is on only in the cycle after a sample strobe.
- R7: While `master_en` is low, `scl_out` is 1 from the next cycle on and the sample strobe keeps running. After `master_en` rises, SCL first falls after exactly 5·(M+1) sample strobes.
- R8: A new N takes effect only at the next sample-strobe wrap. The interval in progress keeps the old length. A new M takes effect only at the next SCL toggle.
- R9: `scl_rise` (`scl_fall`) is high for exactly the first cycle in which `scl_out` is newly 1 (0). This includes the release to 1 when master mode is turned off while SCL is low. Neither pulses at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control byte |
| cfg_wr_data | input | 8 | Control byte: [6:3] M, [2:0] N, [7] reserved |
| master_en | input | 1 | Master mode enable; low releases SCL |
| samp_stb | output | 1 | One-cycle bus sample strobe |
| scl_out | output | 1 | SCL level (1 = released) |
| scl_rise | output | 1 | One-cycle pulse on a new high SCL level |
| scl_fall | output | 1 | One-cycle pulse on a new low SCL level |

## Verification
A prescaler count that is off by one, or a stale exponent, shows up as a sample-strobe interval of the wrong length. It appears on the first interval after the new N should have been adopted. A wrong half-period count, or a late scalar update, shows up within one SCL half period as a level that lasts the wrong number of clocks or strobes. A broken release path shows up in the first cycle after master mode drops. A misplaced edge strobe shows up on the very SCL transition it should mark.

// File: rtl/i2c_rate_pkg.sv
// Package: shared widths and the decoded rate configuration type for the
// two-stage I2C rate generator. Assumes the control byte is CFG_W bits wide
// with the exponent in the low bits and the scalar just above it.
package i2c_rate_pkg;

    localparam int unsigned CFG_W     = 8;   // control byte width
    localparam int unsigned N_W       = 3;   // exponent field width
    localparam int unsigned M_W       = 4;   // scalar field width
    localparam int unsigned HALF_UNIT = 5;   // strobes per half period per (M+1)

    typedef struct packed {
        logic [M_W-1:0] m;   // SCL scalar
        logic [N_W-1:0] n;   // prescaler exponent
    } rate_cfg_t;

endpackage

// File: rtl/i2c_rate_cfg.sv
// Module: i2c_rate_cfg
// Holds the write-only rate control byte. It decodes the scalar and the
// exponent on a write and drops the reserved top bit.
// Assumes: a single write port with no read path. The status register that
// shares the address is decoded elsewhere.
module i2c_rate_cfg
    import i2c_rate_pkg::*;
#(
    parameter int unsigned DATA_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output rate_cfg_t         cfg
);

    localparam int unsigned FIELD_TOP = N_W + M_W;

    // reserved bits are deliberately not stored
    logic unused_rsvd;
    assign unused_rsvd = ^wr_data[DATA_W-1:FIELD_TOP];

    // capture the decoded fields on a write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.m <= wr_data[FIELD_TOP-1:N_W];
            cfg.n <= wr_data[N_W-1:0];
        end
    end

    // R1: the stored fields follow the written byte positions
    a_r1_field_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg.n == $past(wr_data[N_W-1:0])) &&
                  (cfg.m == $past(wr_data[FIELD_TOP-1:N_W])));

    // R1: without a write the fields hold
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));

endmodule

// File: rtl/i2c_rate_prescale.sv
// Module: i2c_rate_prescale
// First stage. A free-running counter wraps every 2^N system clocks and
// emits a one-cycle sample strobe on the wrap cycle. The exponent is
// adopted only at a wrap, so the interval in progress always completes.
// Assumes: N fits in N_W bits, so the counter needs 2^N_W - 1 bits.
module i2c_rate_prescale
    import i2c_rate_pkg::*;
#(
    parameter int unsigned EXP_W = N_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] n_cfg,
    output logic             samp_stb
);

    localparam int unsigned PRE_W = (1 << EXP_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [EXP_W-1:0] n_act;
    logic [PRE_W-1:0] pre_lim;
    logic             pre_wrap;

    // terminal count for the exponent in force: 2^N - 1
    always_comb begin
        pre_lim  = PRE_W'((32'd1 << n_act) - 32'd1);
        pre_wrap = (pre_cnt == pre_lim);
    end

    assign samp_stb = pre_wrap;

    // advance the counter and take up a new exponent only at wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            n_act   <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            n_act   <= n_cfg;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R3: the counter never passes its terminal count
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= pre_lim);

    // R3: every strobe restarts the interval from zero
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |=> (pre_cnt == '0));

    // R8: the exponent in force changes only at a wrap
    a_r8_exp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_stb |=> $stable(n_act));

endmodule

// File: rtl/i2c_rate_scl_div.sv
// Module: i2c_rate_scl_div
// Second stage. It counts sample strobes and toggles SCL after every
// HALF_UNIT*(M+1) of them. It emits one-cycle strobes on the first cycle
// of each new SCL level. With master mode off, SCL is released high and
// the counter is parked at zero. The scalar is adopted only at a toggle,
// or at any time while idle.
// Assumes: samp_stb is a single-cycle pulse from the prescaler.
module i2c_rate_scl_div
    import i2c_rate_pkg::*;
#(
    parameter int unsigned SCAL_W = M_W,
    parameter int unsigned UNIT   = HALF_UNIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_stb,
    input  logic              master_en,
    input  logic [SCAL_W-1:0] m_cfg,
    output logic              scl_out,
    output logic              scl_rise,
    output logic              scl_fall
);

    localparam int unsigned HALF_MAX = UNIT * (1 << SCAL_W);
    localparam int unsigned HC_W     = $clog2(HALF_MAX);

    logic [HC_W-1:0]   half_cnt;
    logic [HC_W-1:0]   half_lim;
    logic [SCAL_W-1:0] m_act;
    logic              scl_q;
    logic              half_end;

    // terminal strobe count for the scalar in force
    always_comb begin
        half_lim = HC_W'(UNIT * (32'(m_act) + 32'd1) - 32'd1);
        half_end = samp_stb && (half_cnt == half_lim);
    end

    assign scl_out = scl_q;

    // count strobes, toggle SCL at half-period end, release when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            m_act    <= '0;
            scl_q    <= 1'b1;
            scl_rise <= 1'b0;
            scl_fall <= 1'b0;
        end else if (!master_en) begin
            half_cnt <= '0;
            m_act    <= m_cfg;
            scl_q    <= 1'b1;
            scl_rise <= ~scl_q;
            scl_fall <= 1'b0;
        end else if (half_end) begin
            half_cnt <= '0;
            m_act    <= m_cfg;
            scl_q    <= ~scl_q;
            scl_rise <= ~scl_q;
            scl_fall <= scl_q;
        end else begin
            if (samp_stb) begin
                half_cnt <= half_cnt + 1'b1;
            end
            scl_rise <= 1'b0;
            scl_fall <= 1'b0;
        end
    end

    // R4: the strobe count stays inside one half period
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        half_cnt <= half_lim);

    // R6: in master mode SCL moves only right after a sample strobe
    a_r6_move_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(master_en) && (scl_out != $past(scl_out))) |-> $past(samp_stb));

    // R7: idle releases SCL and parks the counter
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (scl_out && (half_cnt == '0)));

    // R8: the scalar in force changes only at a toggle while active
    a_r8_scal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && !half_end) |=> $stable(m_act));

    // R9: edge strobes coincide with a fresh level
    a_r9_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (scl_out && !$past(scl_out)));

    a_r9_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> (!scl_out && $past(scl_out)));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall}));

endmodule

// File: rtl/i2c_rate_gen.sv
// Module: i2c_rate_gen
// Top of the two-stage I2C rate generator. It chains the control byte
// register, the 2^N prescaler and the 10*(M+1) SCL divider.
// Assumes: one system clock domain and synchronous active-low reset. The
// read-only status register at the same address is outside this block.
module i2c_rate_gen
    import i2c_rate_pkg::*;
#(
    parameter int unsigned DATA_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic              master_en,
    output logic              samp_stb,
    output logic              scl_out,
    output logic              scl_rise,
    output logic              scl_fall
);

    rate_cfg_t cfg_q;

    i2c_rate_cfg #(
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg     (cfg_q)
    );

    i2c_rate_prescale #(
        .EXP_W (N_W)
    ) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .n_cfg    (cfg_q.n),
        .samp_stb (samp_stb)
    );

    i2c_rate_scl_div #(
        .SCAL_W (M_W),
        .UNIT   (HALF_UNIT)
    ) u_scl_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_stb  (samp_stb),
        .master_en (master_en),
        .m_cfg     (cfg_q.m),
        .scl_out   (scl_out),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    // R2: no edge strobe while reset is held
    a_r2_quiet_reset: assert property (@(posedge clk)
        !rst_n |=> (!scl_rise && !scl_fall && scl_out));

endmodule

// File: tb/i2c_rate_gen_bench.sv
// Bench for i2c_rate_gen: seeded random configurations mixed with directed
// corners. Each result is checked against timing computed from M and N.
module i2c_rate_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic       master_en = 1'b0;
    logic       samp_stb;
    logic       scl_out;
    logic       scl_rise;
    logic       scl_fall;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam int WATCHDOG_CYC = 150000;

    i2c_rate_gen u_i2c_rate_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .master_en   (master_en),
        .samp_stb    (samp_stb),
        .scl_out     (scl_out),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_stb_gap(int n);
        return 1 << n;
    endfunction

    function automatic int exp_half_stb(int m);
        return 5 * (m + 1);
    endfunction

    function automatic int exp_half_cyc(int m, int n);
        return 5 * (m + 1) * (1 << n);
    endfunction

    task automatic check_eq(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic write_cfg(bit rsvd, int m, int n);
        cfg_wr_data = {rsvd, 4'(m), 3'(n)};
        cfg_wr_en   = 1'b1;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic next_stb(output int t);
        @(negedge clk);
        while (!samp_stb) @(negedge clk);
        t = cyc;
    endtask

    // wait for the next SCL change; counts strobes from the current cycle on
    // and checks the edge strobes and the strobe before the change
    task automatic next_scl_change(output int t, output int sc);
        logic prev;
        logic last;
        bit   quiet_ok;
        prev     = scl_out;
        sc       = 0;
        quiet_ok = 1'b1;
        last     = 1'b0;
        forever begin
            if (samp_stb) sc++;
            last = samp_stb;
            @(negedge clk);
            if (scl_out != prev) break;
            if (scl_rise || scl_fall) quiet_ok = 1'b0;
        end
        t = cyc;
        check_eq("R6", "strobe before SCL change", int'(last), 1);
        check_eq("R9", "rise strobe on new level", int'(scl_rise), int'(scl_out));
        check_eq("R9", "fall strobe on new level", int'(scl_fall), int'(!scl_out));
        check_eq("R9", "no edge strobe between changes", int'(quiet_ok), 1);
    endtask

    task automatic run_cfg(int m, int n, bit rsvd);
        int t0, t1, t2, sc, ta, tb, stb_seen;
        master_en = 1'b0;
        write_cfg(rsvd, m, n);
        repeat (3) next_stb(ta);
        next_stb(ta);
        next_stb(tb);
        check_eq("R3", $sformatf("strobe gap n=%0d rsvd=%0d (R1)", n, rsvd),
                 tb - ta, exp_stb_gap(n));
        if (n > 0) begin
            @(negedge clk);
            check_eq("R3", "strobe width one cycle", int'(samp_stb), 0);
        end
        // enable master mode and time the first fall and two half periods
        master_en = 1'b1;
        next_scl_change(t0, sc);
        check_eq("R7", $sformatf("strobes to first fall m=%0d", m), sc, exp_half_stb(m));
        check_eq("R7", "first change is a fall", int'(scl_out), 0);
        next_scl_change(t1, sc);
        check_eq("R4", $sformatf("low time m=%0d n=%0d", m, n), t1 - t0, exp_half_cyc(m, n));
        check_eq("R4", "strobes in low level", sc, exp_half_stb(m));
        next_scl_change(t2, sc);
        check_eq("R4", $sformatf("high time m=%0d n=%0d", m, n), t2 - t1, exp_half_cyc(m, n));
        // SCL is now low: release it
        master_en = 1'b0;
        @(negedge clk);
        check_eq("R7", "release to high", int'(scl_out), 1);
        check_eq("R9", "rise strobe on release", int'(scl_rise), 1);
        stb_seen = 0;
        t0 = 1;
        for (int i = 0; i < 3 * exp_stb_gap(n) + 2; i++) begin
            @(negedge clk);
            if (!scl_out || scl_rise || scl_fall) t0 = 0;
            if (samp_stb) stb_seen++;
        end
        check_eq("R7", "SCL stays released", t0, 1);
        check_eq("R7", "strobes continue while idle", int'(stb_seen >= 3), 1);
    endtask

    initial begin
        int t0, t1, t2, sc, m, n;
        bit ok;
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        // R2: reset state
        check_eq("R2", "scl during reset", int'(scl_out), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R2", "strobe after reset", int'(samp_stb), 1);
        check_eq("R2", "scl after reset", int'(scl_out), 1);
        check_eq("R2", "no edge strobes", int'(scl_rise | scl_fall), 0);
        @(negedge clk);
        check_eq("R3", "N=0 strobe every cycle", int'(samp_stb), 1);

        // directed corners
        run_cfg(0, 0, 1'b0);
        run_cfg(15, 0, 1'b1);
        run_cfg(0, 7, 1'b0);
        run_cfg(15, 7, 1'b0);

        // R8: a new exponent waits for the current interval to finish
        write_cfg(1'b0, 2, 1);
        repeat (3) next_stb(t0);
        next_stb(t0);
        write_cfg(1'b0, 2, 3);
        next_stb(t1);
        check_eq("R8", "interval in progress keeps old N", t1 - t0, 2);
        next_stb(t2);
        check_eq("R8", "next interval uses new N", t2 - t1, 8);

        // R5 and R8: change M while active at N=2
        write_cfg(1'b0, 1, 2);
        repeat (3) next_stb(t0);
        master_en = 1'b1;
        next_scl_change(t0, sc);
        repeat (3) next_stb(t1);
        write_cfg(1'b0, 5, 2);
        ok = 1'b1;
        next_stb(t1);
        for (int i = 0; i < 3; i++) begin
            next_stb(t2);
            if (t2 - t1 != 4) ok = 1'b0;
            t1 = t2;
        end
        check_eq("R5", "sample gap unchanged by new M", int'(ok), 1);
        next_scl_change(t1, sc);
        check_eq("R8", "half in progress keeps old M", t1 - t0, exp_half_cyc(1, 2));
        next_scl_change(t2, sc);
        check_eq("R8", "next half uses new M", t2 - t1, exp_half_cyc(5, 2));
        master_en = 1'b0;
        @(negedge clk);

        // seeded random configurations
        for (int k = 0; k < 8; k++) begin
            m = int'($urandom % 4);
            n = int'($urandom % 4);
            run_cfg(m, n, 1'($urandom % 2));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R4 watchdog: actual cycle %0d expected finish before %0d",
                     cyc, WATCHDOG_CYC);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule